// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte FIFOs

This block is a bus-attached SPI master. Software talks to it through three 32-bit word registers. One holds control and status. One is a data port: a write pushes a byte into a 16-entry transmit queue, and a read pops a byte from a 16-entry receive queue. The third holds the serial clock divider. While the transfer-active bit is set, the engine takes bytes from the transmit queue and shifts each one out MSB first. For every byte sent it captures one byte from the slave into the receive queue. It supports all four clock polarity and phase combinations.

Three chip-select lines are driven from the control register. Each line has its own polarity. The controller raises a single level interrupt from two flags, each with its own enable:

- a done flag, meaning nothing is left to send;
- a receive-threshold flag, meaning the receive queue is nearly full.

Software sets transfer-active first. It then takes the done interrupt as its cue to fill the transmit queue, and uses the threshold interrupt to drain received bytes while a long burst is still running.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset:
  - every control field is 0 and the divider register reads 0;
  - `sclk` is 0, `irq` is 0, and all chip selects are high (inactive at polarity 0);
  - the control/status word at offset 0x0 reads 0x0005_0000, meaning the done and can-accept bits are set.
- R2: A write to offset 0x4 pushes `wdata[7:0]` into the transmit queue. A read of offset 0x4 returns the oldest received byte in `rdata[7:0]` and removes it. A read of an empty receive queue returns 0 and changes nothing.
- R3: Each byte is shifted out on `mosi` MSB first over 8 `sclk` cycles. The byte captured from `miso` during the same 8 cycles enters the receive queue, so bytes come back in the order they were sent.
- R4: Control bit 3 is the clock idle level, and `sclk` rests at that level between bytes. Control bit 2 selects the capture edge: 0 captures on the leading edge (first bit valid before it), 1 drives on the leading edge and captures on the trailing edge.
- R5: Divider register (offset 0x8, DIV_W bits) semantics:
  - Each `sclk` half period lasts floor(D/2) core clocks.
  - D values 0 and 1 give the slowest rate, with a half period of 2^(DIV_W-1) core clocks.
  - D = 2 gives half the core clock.
- R6: Status bit 16 (done) is 1 exactly when the transmit queue is empty and no byte is being shifted. Setting transfer-active (bit 7) with an empty queue therefore shows done at once.
- R7: Receive queue status bits:
  - bit 17: the queue is non-empty;
  - bit 19: at least 12 bytes are waiting;
  - bit 20: 16 bytes are waiting.
  While the receive queue is full, no new byte starts shifting; the pending byte starts once a read frees a slot.
- R8: Writing 1 to control bit 4 empties the transmit queue, and writing 1 to bit 5 empties the receive queue. Both bits read back as 0.
- R9: Chip-select behaviour:
  - Control bits 1:0 pick the line, and value 3 picks none.
  - Line i is active-high if its own polarity bit (bit 21+i) or the common polarity bit (bit 6) is 1, otherwise active-low.
  - Only the picked line is at its active level, and only while transfer-active is set. Every other line sits at its inactive level.
- R10: `irq` equals (done AND bit 9) OR (bit 19 flag AND bit 10), registered one core clock behind the flags.
- R11: Status bit 18 is 1 while the transmit queue has a free slot. A write to the data port when the queue is full is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the accessed register |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_lines | output | NUM_CS | Chip-select lines |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches every cycle for the following:
- more than one chip select at its active level, or any line active while transfer-active is clear;
- `sclk` away from its idle level while no byte is in flight;
- `irq` not following its registered equation;
- a queue count past its depth;
- a byte starting while the receive queue is full.

Only the bench scenarios can show the rest:
- bit order and the choice of capture edge in each of the four modes, through a scoreboard of expected `mosi` bytes and expected received bytes;
- the measured half-period for several divider values, including the wrap of 0;
- the effects of the clear bits, the dropped seventeenth write, and the stall-and-resume around a full receive queue.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
   localparam int BYTE_W   = 8;
   localparam int REG_W    = 32;
   // register offsets
   localparam int OFF_CTRL = 0;
   localparam int OFF_DATA = 4;
   localparam int OFF_DIV  = 8;
   // control / status bit positions
   localparam int B_CPHA    = 2;
   localparam int B_CPOL    = 3;
   localparam int B_CLR_TX  = 4;
   localparam int B_CLR_RX  = 5;
   localparam int B_CSPOL   = 6;
   localparam int B_ACTIVE  = 7;
   localparam int B_EN_DONE = 9;
   localparam int B_EN_RXR  = 10;
   localparam int B_DONE    = 16;
   localparam int B_RXD     = 17;
   localparam int B_TXD     = 18;
   localparam int B_RXR     = 19;
   localparam int B_RXF     = 20;
   localparam int B_LPOL    = 21;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_byte_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (clr) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int W     = 8,
   parameter int DIV_W = 16,
   localparam int EW   = $clog2(2 * W),
   localparam int TW   = DIV_W - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpol,
   input  logic          cpha,
   input  logic [TW-1:0] half,
   input  logic          active,
   input  logic          tx_valid,
   input  logic [W-1:0]  tx_data,
   input  logic          rx_ready,
   output logic          tx_pop,
   output logic          rx_push,
   output logic [W-1:0]  rx_data,
   output logic          busy,
   output logic          sclk,
   output logic          mosi,
   input  logic          miso
);
   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("spi_shift_engine: DIV_W must be at least 2");
      end
   endgenerate

   logic [TW-1:0] tmr;
   logic [EW-1:0] edge_idx;
   logic [W-1:0]  tx_sh, rx_sh;
   logic          tgl, mosi_q, tick, sample, drive, last;

   assign tx_pop  = active && tx_valid && rx_ready && !busy;
   assign tick    = busy && (tmr == half - 1'b1);
   assign sample  = tick && (edge_idx[0] == cpha);
   assign drive   = tick && (edge_idx[0] != cpha);
   assign last    = (edge_idx == EW'(2 * W - 1));
   assign rx_push = tick && last;
   assign rx_data = cpha ? {rx_sh[W-2:0], miso} : rx_sh;
   assign sclk    = cpol ^ tgl;
   assign mosi    = mosi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         tmr      <= '0;
         edge_idx <= '0;
         tgl      <= 1'b0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         mosi_q   <= 1'b0;
      end else if (!busy) begin
         tmr      <= '0;
         edge_idx <= '0;
         tgl      <= 1'b0;
         if (tx_pop) begin
            busy  <= 1'b1;
            tx_sh <= tx_data;
            if (!cpha) mosi_q <= tx_data[W-1];
         end
      end else if (tick) begin
         tmr      <= '0;
         tgl      <= ~tgl;
         edge_idx <= edge_idx + 1'b1;
         if (sample) rx_sh <= {rx_sh[W-2:0], miso};
         if (drive) begin
            mosi_q <= cpha ? tx_sh[W-1] : tx_sh[W-2];
            tx_sh  <= {tx_sh[W-2:0], 1'b0};
         end
         if (last) busy <= 1'b0;
      end else begin
         tmr <= tmr + 1'b1;
      end
   end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
   import spi_fifo_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DEPTH     = 16,
   parameter int RX_THRESH = 12,
   parameter int DIV_W     = 16,
   parameter int NUM_CS    = 3,
   localparam int CW       = $clog2(DEPTH + 1),
   localparam int SEL_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   input  logic              rd_en,
   output logic [31:0]       rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_lines,
   output logic              irq
);
   generate
      if (NUM_CS < 1 || NUM_CS > 3) begin : g_bad_cs
         $error("spi_fifo_master: NUM_CS must be 1 to 3");
      end
      if (RX_THRESH < 1 || RX_THRESH > DEPTH) begin : g_bad_thr
         $error("spi_fifo_master: RX_THRESH out of range");
      end
      if (DIV_W > 16) begin : g_bad_divw
         $error("spi_fifo_master: DIV_W must fit the register word");
      end
   endgenerate

   logic [SEL_W-1:0]  sel_q;
   logic              cpha_q, cpol_q, cspol_q, active_q, en_done_q, en_rxr_q;
   logic [NUM_CS-1:0] lpol_q, pol_eff;
   logic [DIV_W-1:0]  div_q;

   logic              wr_ctrl, wr_data, rd_data, wr_div;
   logic              clr_tx, clr_rx;
   logic [CW-1:0]     tx_count, rx_count;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic [BYTE_W-1:0] tx_head, rx_head, rx_byte;
   logic              tx_pop, rx_push, busy;
   logic              st_done, st_rxr;

   assign wr_ctrl = wr_en && (addr == ADDR_W'(OFF_CTRL));
   assign wr_data = wr_en && (addr == ADDR_W'(OFF_DATA));
   assign wr_div  = wr_en && (addr == ADDR_W'(OFF_DIV));
   assign rd_data = rd_en && (addr == ADDR_W'(OFF_DATA));
   assign clr_tx  = wr_ctrl && wdata[B_CLR_TX];
   assign clr_rx  = wr_ctrl && wdata[B_CLR_RX];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= '0;
         cpha_q    <= 1'b0;
         cpol_q    <= 1'b0;
         cspol_q   <= 1'b0;
         active_q  <= 1'b0;
         en_done_q <= 1'b0;
         en_rxr_q  <= 1'b0;
         lpol_q    <= '0;
         div_q     <= '0;
      end else begin
         if (wr_ctrl) begin
            sel_q     <= wdata[SEL_W-1:0];
            cpha_q    <= wdata[B_CPHA];
            cpol_q    <= wdata[B_CPOL];
            cspol_q   <= wdata[B_CSPOL];
            active_q  <= wdata[B_ACTIVE];
            en_done_q <= wdata[B_EN_DONE];
            en_rxr_q  <= wdata[B_EN_RXR];
            lpol_q    <= wdata[B_LPOL +: NUM_CS];
         end
         if (wr_div) div_q <= wdata[DIV_W-1:0];
      end
   end

   spi_byte_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(clr_tx), .push(wr_data),
      .din(wdata[BYTE_W-1:0]), .pop(tx_pop), .dout(tx_head),
      .count(tx_count), .empty(tx_empty), .full(tx_full));

   spi_byte_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(clr_rx), .push(rx_push),
      .din(rx_byte), .pop(rd_data), .dout(rx_head),
      .count(rx_count), .empty(rx_empty), .full(rx_full));

   spi_shift_engine #(.W(BYTE_W), .DIV_W(DIV_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .cpol(cpol_q), .cpha(cpha_q),
      .half(div_q[DIV_W-1:1]), .active(active_q),
      .tx_valid(!tx_empty), .tx_data(tx_head), .rx_ready(!rx_full),
      .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_byte),
      .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso));

   assign st_done = tx_empty && !busy;
   assign st_rxr  = (rx_count >= CW'(RX_THRESH));

   generate
      for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
         assign pol_eff[i]  = lpol_q[i] | cspol_q;
         assign cs_lines[i] = (active_q && sel_q == SEL_W'(i)) ? pol_eff[i] : ~pol_eff[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= (st_done && en_done_q) || (st_rxr && en_rxr_q);
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFF_CTRL)) begin
         rdata[SEL_W-1:0]         = sel_q;
         rdata[B_CPHA]            = cpha_q;
         rdata[B_CPOL]            = cpol_q;
         rdata[B_CSPOL]           = cspol_q;
         rdata[B_ACTIVE]          = active_q;
         rdata[B_EN_DONE]         = en_done_q;
         rdata[B_EN_RXR]          = en_rxr_q;
         rdata[B_DONE]            = st_done;
         rdata[B_RXD]             = !rx_empty;
         rdata[B_TXD]             = !tx_full;
         rdata[B_RXR]             = st_rxr;
         rdata[B_RXF]             = rx_full;
         rdata[B_LPOL +: NUM_CS]  = lpol_q;
      end else if (addr == ADDR_W'(OFF_DATA)) begin
         rdata[BYTE_W-1:0] = rx_empty ? '0 : rx_head;
      end else if (addr == ADDR_W'(OFF_DIV)) begin
         rdata[DIV_W-1:0] = div_q;
      end
   end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
   parameter int NUM_CS = 3,
   parameter int DEPTH  = 16,
   parameter int CW     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CS-1:0] cs_lines,
   input logic [NUM_CS-1:0] pol_eff,
   input logic              active,
   input logic              cpol,
   input logic              sclk,
   input logic              busy,
   input logic              done,
   input logic              rxr,
   input logic              en_done,
   input logic              en_rxr,
   input logic              irq,
   input logic [CW-1:0]     tx_count,
   input logic [CW-1:0]     rx_count
);
   logic [NUM_CS-1:0] on_lines;
   assign on_lines = ~(cs_lines ^ pol_eff);

   assert_one_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(on_lines));
   assert_cs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (on_lines == '0));
   assert_sclk_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == cpol));
   assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past((done && en_done) || (rxr && en_rxr)));
   assert_rx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CW'(DEPTH));
   assert_tx_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= CW'(DEPTH));
   assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == CW'(DEPTH) && !busy) |=> !busy);
   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && tx_count == '0));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.NUM_CS(NUM_CS), .DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_lines(cs_lines), .pol_eff(pol_eff),
   .active(active_q), .cpol(cpol_q), .sclk(sclk), .busy(busy),
   .done(st_done), .rxr(st_rxr), .en_done(en_done_q), .en_rxr(en_rxr_q),
   .irq(irq), .tx_count(tx_count), .rx_count(rx_count));

// File: tb/sim_spi_fifo_master.sv
module sim_spi_fifo_master;
   localparam int DIV_W = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        sclk, mosi, miso;
   logic [2:0]  cs_lines;
   logic        irq;

   int n_chk = 0, n_fail = 0;
   longint cyc = 0;
   bit timed_out = 0;

   logic [7:0] exp_mosi[$];
   logic [7:0] exp_rx[$];
   logic       cpol_m = 0, cpha_m = 0;
   int         half_m = 128;

   assign miso = ~mosi;

   spi_fifo_master #(.DIV_W(DIV_W)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rd_en(rd_en), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
      .cs_lines(cs_lines), .irq(irq));

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: rebuilds each byte seen on mosi and times sclk edges
   logic       prev_t = 0;
   int         eidx = 0;
   longint     last_edge = 0;
   logic [7:0] mon_byte = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if ((sclk ^ cpol_m) != prev_t) begin
            if (eidx > 0) check("R5 half period", cyc - last_edge, half_m);
            last_edge = cyc;
            if ((eidx % 2) == cpha_m) mon_byte = {mon_byte[6:0], mosi};
            eidx++;
            if (eidx == 16) begin
               eidx = 0;
               if (exp_mosi.size() == 0) check("R3 unexpected byte", mon_byte, 0);
               else check("R3/R4 mosi byte", mon_byte, exp_mosi.pop_front());
            end
         end
         prev_t = sclk ^ cpol_m;
      end
   end

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      #1;
      if (a == 4'h0) begin cpol_m = d[3]; cpha_m = d[2]; end
      if (a == 4'h8) half_m = (d[DIV_W-1:1] == 0) ? (1 << (DIV_W-1)) : int'(d[DIV_W-1:1]);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      exp_mosi.push_back(b);
      exp_rx.push_back(~b);
      bus_write(4'h4, {24'h0, b});
   endtask

   task automatic read_data(input string req);
      logic [31:0] d;
      bus_read(4'h4, d);
      if (exp_rx.size() == 0) check({req, " empty read"}, d, 0);
      else check({req, " rx byte"}, d, {24'h0, exp_rx.pop_front()});
   endtask

   task automatic ctrl_bit(input string req, input int bitpos, input logic exp);
      logic [31:0] d;
      bus_read(4'h0, d);
      check(req, d[bitpos], exp);
   endtask

   task automatic wait_done();
      logic [31:0] d;
      for (int i = 0; i < 4000; i++) begin
         bus_read(4'h0, d);
         if (d[16]) return;
      end
      check("R6 done reached", 0, 1);
   endtask

   task automatic run();
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      bus_read(4'h0, d); check("R1 ctrl reset", d, 32'h0005_0000);
      bus_read(4'h8, d); check("R1 div reset", d, 0);
      check("R1 cs reset", cs_lines, 3'b111);
      check("R1 sclk reset", sclk, 0);
      check("R1 irq reset", irq, 0);
      bus_read(4'h4, d); check("R2 empty read", d, 0);

      // mode 0, divider 4, line 0, done interrupt
      bus_write(4'h8, 4);
      bus_write(4'h0, 32'h280);
      @(negedge clk);
      check("R6/R10 irq on empty active", irq, 1);
      check("R9 cs line0 low", cs_lines, 3'b110);
      send(8'hA5); send(8'h3C); send(8'h81);
      wait_done();
      repeat (3) read_data("R2/R3");
      @(negedge clk);
      check("R10 irq after done", irq, 1);

      // mode 3, divider 6, line 1
      bus_write(4'h8, 6);
      bus_write(4'h0, 32'h8D);
      check("R4 sclk idle high", sclk, 1);
      check("R9 cs line1 low", cs_lines, 3'b101);
      send(8'h96); send(8'h01);
      wait_done();
      repeat (2) read_data("R4 mode3");

      // mode 1, odd divider 7 -> half 3, line 2
      bus_write(4'h8, 7);
      bus_write(4'h0, 32'h86);
      check("R9 cs line2 low", cs_lines, 3'b011);
      send(8'h5A);
      wait_done();
      read_data("R4 mode1");

      // mode 2, divider 0 -> slowest
      bus_write(4'h8, 0);
      bus_write(4'h0, 32'h88);
      check("R4 mode2 idle high", sclk, 1);
      send(8'hC3);
      wait_done();
      read_data("R4 mode2");

      // chip-select polarity cases
      bus_write(4'h0, 32'h83);
      check("R9 select 3 none", cs_lines, 3'b111);
      bus_write(4'h0, 32'hC2);
      check("R9 common pol active", cs_lines, 3'b100);
      bus_write(4'h0, 32'h42);
      check("R9 common pol inactive", cs_lines, 3'b000);
      bus_write(4'h0, 32'h0040_0080);
      check("R9 line pol mix", cs_lines, 3'b100);

      // full queues, stall and thresholds
      bus_write(4'h8, 2);
      bus_write(4'h0, 32'h0);
      for (int i = 0; i < 16; i++) send(8'(8'h10 + i * 7));
      bus_write(4'h4, 32'hEE);   // dropped
      ctrl_bit("R11 tx full", 18, 0);
      ctrl_bit("R6 not done with data", 16, 0);
      bus_write(4'h0, 32'h80);
      wait_done();
      ctrl_bit("R7 rx full", 20, 1);
      ctrl_bit("R7 rx thresh", 19, 1);
      send(8'h77);
      repeat (40) @(negedge clk);
      ctrl_bit("R7 stall while full", 16, 0);
      read_data("R7");
      wait_done();
      ctrl_bit("R7 full again", 20, 1);
      repeat (4) read_data("R11");
      ctrl_bit("R7 at 12 thresh", 19, 1);
      ctrl_bit("R7 at 12 not full", 20, 0);
      bus_write(4'h0, 32'h480);
      @(negedge clk);
      check("R10 irq on rx thresh", irq, 1);
      read_data("R7");
      ctrl_bit("R7 at 11 below", 19, 0);
      @(negedge clk);
      check("R10 irq drops", irq, 0);
      bus_write(4'h0, 32'hA0);
      exp_rx.delete();
      ctrl_bit("R8 rx cleared", 17, 0);
      read_data("R8/R2");

      // transmit clear
      bus_write(4'h0, 32'h0);
      bus_write(4'h4, 32'h11);
      bus_write(4'h4, 32'h22);
      ctrl_bit("R6 pending data", 16, 0);
      bus_write(4'h0, 32'h10);
      bus_read(4'h0, d);
      check("R8 clear bits read 0", d[5:4], 0);
      check("R8 tx cleared done", d[16], 1);
      check("R11 tx accepts", d[18], 1);
      check("R3 all bytes seen", exp_mosi.size(), 0);
   endtask

   initial begin
      fork
         run();
         begin
            wait (cyc > 150000);
            timed_out = 1;
         end
      join_any
      if (timed_out) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule